// File: doc/BRIEF.md
# Per-Port Source Address Monitor

This block watches nine receive ports of a repeater: eight twisted-pair ports and one AUI port. Each port delivers a one-cycle frame-valid strobe together with the 48-bit source address of the frame. For every port the block holds the last source address it has seen. It flags a port when a frame arrives from a station other than the one last seen there. Software can preload that store with the node ID it expects, so a change of station on a single-station segment shows up as a status event.

A single programmable match address is compared against every arriving source address. The port where that node appears gets its own match flag, which lets software find which port a given station is attached to. Status and enable bits are reached through a paged register interface: a 5-bit page field, a 5-bit register field and 8-bit data. Any status bit whose enable is set drives one active-high interrupt output.

Top module: `sa_port_monitor`

## Requirements
- R1: A synchronous active-high reset clears every status bit, every enable bit, the match address and the record of which ports have a known address. After reset, irq is low and register reads return 0.
- R2: After reset, the first valid frame on a port sets that port's address-changed status bit, whatever its source address is.
- R3: A valid frame whose source address differs from the port's stored address sets the port's address-changed bit, and a frame with an equal address does not. In both cases the stored address becomes the frame's address.
- R4: The stored address of port p (0 to 8, port 8 = AUI) is read and written on page 16+p, registers 0 to 5, with register 0 holding address bits 7:0 and register 5 bits 47:40. A write marks the port's address as known, so a later frame with the preloaded address does not set address-changed.
- R5: The match address sits on page 3, registers 0 to 5, in the same byte order. A valid frame whose source address equals it sets that port's address-match bit.
- R6: Page 1 holds the status bits. Register 6 holds the TP address-changed bits (bit n = port n). Register 7 holds the AUI address-changed bit in bit 7. Register 8 holds the TP address-match bits. Register 9 holds the AUI address-match bit in bit 7. The unused bits of registers 7 and 9 read 0.
- R7: Status registers are read-only, and writes to them are ignored. A read returns the register's value in the cycle after the read strobe and clears the register's bits.
- R8: If a status bit is being set by a frame in the same cycle that a read clears it, the bit ends up set.
- R9: Page 2 registers 6 to 9 hold the interrupt enables, with the same bit layout as page 1 registers 6 to 9. They read back what was written, and reading them does not change them.
- R10: irq is high exactly when some status bit and its enable are both 1. It rises in the cycle after the frame strobe that sets an enabled bit. It falls in the cycle after the enable is written to 0 or the bit is cleared by a read.
- R11: A condition that persists after its bit was read and cleared sets the bit again on the next qualifying frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | NUM_TP+1 | Per-port frame-valid strobe, bit 8 = AUI |
| rx_sa | input | (NUM_TP+1) x ADDR_W | Per-port source address, qualified by rx_valid |
| reg_page | input | 5 | Register page select |
| reg_addr | input | 5 | Register select within the page |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid the cycle after reg_rd |
| irq | output | 1 | Active-high interrupt |

## Verification
The hardest situation to reach from the ports is a read that clears a status register in the same clock in which a frame sets a bit of that register. The stimulus drives the read strobe and the frame strobe at the same falling edge. The scoreboard expects the pre-clear value, and a follow-up read must still find the new bit. The interrupt is also exercised without changing any status: an enabled, pending bit has its enable written to 0 and then back to 1, and the output must follow both writes.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int FIELD_W = 5;
  localparam int DATA_W  = 8;

  localparam logic [FIELD_W-1:0] PG_STATUS = 5'd1;
  localparam logic [FIELD_W-1:0] PG_CTRL   = 5'd2;
  localparam logic [FIELD_W-1:0] PG_MATCH  = 5'd3;
  localparam logic [FIELD_W-1:0] PG_STORE0 = 5'd16;

  localparam logic [FIELD_W-1:0] RG_TP_CHG  = 5'd6;
  localparam logic [FIELD_W-1:0] RG_AUI_CHG = 5'd7;
  localparam logic [FIELD_W-1:0] RG_TP_MAT  = 5'd8;
  localparam logic [FIELD_W-1:0] RG_AUI_MAT = 5'd9;
endpackage

// File: rtl/sam_port_tracker.sv
module sam_port_tracker #(
  parameter int ADDR_W = 48,
  parameter int NB     = ADDR_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_v,
  input  logic [ADDR_W-1:0] frame_sa,
  input  logic [ADDR_W-1:0] match_sa,
  input  logic [NB-1:0]     wr_byte,
  input  logic [7:0]        wr_data,
  output logic [ADDR_W-1:0] last_sa,
  output logic              chg_evt,
  output logic              mat_evt
);
  logic              known_q;
  logic [ADDR_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst)
      known_q <= 1'b0;
    else if (frame_v || (|wr_byte))
      known_q <= 1'b1;
  end

  // address store has no reset: its content is undefined until first use
  always_ff @(posedge clk) begin
    if (frame_v)
      last_q <= frame_sa;
    else
      for (int b = 0; b < NB; b++)
        if (wr_byte[b])
          last_q[b*8 +: 8] <= wr_data;
  end

  assign last_sa = last_q;
  assign chg_evt = frame_v && (!known_q || (frame_sa != last_q));
  assign mat_evt = frame_v && (frame_sa == match_sa);
endmodule

// File: rtl/sam_status_bank.sv
module sam_status_bank #(
  parameter int NP = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NP-1:0] chg_evt,
  input  logic [NP-1:0] mat_evt,
  input  logic [NP-1:0] clr_chg,
  input  logic [NP-1:0] clr_mat,
  input  logic [NP-1:0] en_chg_we,
  input  logic [NP-1:0] en_mat_we,
  input  logic [NP-1:0] en_chg_d,
  input  logic [NP-1:0] en_mat_d,
  output logic [NP-1:0] st_chg,
  output logic [NP-1:0] st_mat,
  output logic [NP-1:0] en_chg,
  output logic [NP-1:0] en_mat,
  output logic          irq
);
  always_ff @(posedge clk) begin
    if (rst) begin
      st_chg <= '0;
      st_mat <= '0;
      en_chg <= '0;
      en_mat <= '0;
    end else begin
      // a new event outranks a read-clear in the same cycle
      st_chg <= (st_chg & ~clr_chg) | chg_evt;
      st_mat <= (st_mat & ~clr_mat) | mat_evt;
      en_chg <= (en_chg & ~en_chg_we) | (en_chg_d & en_chg_we);
      en_mat <= (en_mat & ~en_mat_we) | (en_mat_d & en_mat_we);
    end
  end

  assign irq = |((st_chg & en_chg) | (st_mat & en_mat));
endmodule

// File: rtl/sam_reg_if.sv
module sam_reg_if
  import sam_pkg::*;
#(
  parameter int NUM_TP = 8,
  parameter int ADDR_W = 48,
  parameter int NP     = NUM_TP + 1,
  parameter int NB     = ADDR_W / 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [FIELD_W-1:0]         page,
  input  logic [FIELD_W-1:0]         addr,
  input  logic                       wr,
  input  logic                       rd,
  input  logic [DATA_W-1:0]          wdata,
  input  logic [NP-1:0]              st_chg,
  input  logic [NP-1:0]              st_mat,
  input  logic [NP-1:0]              en_chg,
  input  logic [NP-1:0]              en_mat,
  input  logic [NP-1:0][ADDR_W-1:0]  last_sa,
  output logic [NP-1:0]              clr_chg,
  output logic [NP-1:0]              clr_mat,
  output logic [NP-1:0]              en_chg_we,
  output logic [NP-1:0]              en_mat_we,
  output logic [NP-1:0]              en_chg_d,
  output logic [NP-1:0]              en_mat_d,
  output logic [NP-1:0][NB-1:0]      store_wr,
  output logic [ADDR_W-1:0]          match_sa,
  output logic [DATA_W-1:0]          rdata
);
  logic [ADDR_W-1:0] match_q;
  logic [DATA_W-1:0] rd_mux;
  logic s_tp_chg, s_aui_chg, s_tp_mat, s_aui_mat;
  logic c_tp_chg, c_aui_chg, c_tp_mat, c_aui_mat;

  function automatic logic [DATA_W-1:0] tp_byte(input logic [NP-1:0] v);
    logic [DATA_W-1:0] r;
    r = '0;
    r[NUM_TP-1:0] = v[NUM_TP-1:0];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] aui_byte(input logic [NP-1:0] v);
    return {v[NP-1], 7'b0};
  endfunction

  assign s_tp_chg  = (page == PG_STATUS) && (addr == RG_TP_CHG);
  assign s_aui_chg = (page == PG_STATUS) && (addr == RG_AUI_CHG);
  assign s_tp_mat  = (page == PG_STATUS) && (addr == RG_TP_MAT);
  assign s_aui_mat = (page == PG_STATUS) && (addr == RG_AUI_MAT);
  assign c_tp_chg  = (page == PG_CTRL) && (addr == RG_TP_CHG);
  assign c_aui_chg = (page == PG_CTRL) && (addr == RG_AUI_CHG);
  assign c_tp_mat  = (page == PG_CTRL) && (addr == RG_TP_MAT);
  assign c_aui_mat = (page == PG_CTRL) && (addr == RG_AUI_MAT);

  assign clr_chg   = rd ? {s_aui_chg, {NUM_TP{s_tp_chg}}} : '0;
  assign clr_mat   = rd ? {s_aui_mat, {NUM_TP{s_tp_mat}}} : '0;
  assign en_chg_we = wr ? {c_aui_chg, {NUM_TP{c_tp_chg}}} : '0;
  assign en_mat_we = wr ? {c_aui_mat, {NUM_TP{c_tp_mat}}} : '0;
  assign en_chg_d  = {wdata[7], wdata[NUM_TP-1:0]};
  assign en_mat_d  = {wdata[7], wdata[NUM_TP-1:0]};

  always_comb begin
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++)
        store_wr[p][b] = wr && (page == PG_STORE0 + FIELD_W'(p)) &&
                         (addr == FIELD_W'(b));
  end

  always_ff @(posedge clk) begin
    if (rst)
      match_q <= '0;
    else if (wr && (page == PG_MATCH))
      for (int b = 0; b < NB; b++)
        if (addr == FIELD_W'(b))
          match_q[b*8 +: 8] <= wdata;
  end
  assign match_sa = match_q;

  always_comb begin
    rd_mux = '0;
    if (page == PG_STATUS || page == PG_CTRL) begin
      case (addr)
        RG_TP_CHG:  rd_mux = tp_byte(page == PG_STATUS ? st_chg : en_chg);
        RG_AUI_CHG: rd_mux = aui_byte(page == PG_STATUS ? st_chg : en_chg);
        RG_TP_MAT:  rd_mux = tp_byte(page == PG_STATUS ? st_mat : en_mat);
        RG_AUI_MAT: rd_mux = aui_byte(page == PG_STATUS ? st_mat : en_mat);
        default:    rd_mux = '0;
      endcase
    end
    for (int b = 0; b < NB; b++)
      if (page == PG_MATCH && addr == FIELD_W'(b))
        rd_mux = match_q[b*8 +: 8];
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < NB; b++)
        if (page == PG_STORE0 + FIELD_W'(p) && addr == FIELD_W'(b))
          rd_mux = last_sa[p][b*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= rd_mux;
  end
endmodule

// File: rtl/sa_port_monitor.sv
module sa_port_monitor
  import sam_pkg::*;
#(
  parameter int NUM_TP = 8,
  parameter int ADDR_W = 48
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_TP:0]               rx_valid,
  input  logic [NUM_TP:0][ADDR_W-1:0]   rx_sa,
  input  logic [FIELD_W-1:0]            reg_page,
  input  logic [FIELD_W-1:0]            reg_addr,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  output logic                          irq
);
  localparam int NP = NUM_TP + 1;
  localparam int NB = ADDR_W / 8;

  logic [NP-1:0][ADDR_W-1:0] last_sa;
  logic [NP-1:0][NB-1:0]     store_wr;
  logic [ADDR_W-1:0]         match_sa;
  logic [NP-1:0] chg_evt, mat_evt, clr_chg, clr_mat;
  logic [NP-1:0] en_chg_we, en_mat_we, en_chg_d, en_mat_d;
  logic [NP-1:0] st_chg, st_mat, en_chg, en_mat;

  for (genvar g = 0; g < NP; g++) begin : g_port
    sam_port_tracker #(.ADDR_W(ADDR_W), .NB(NB)) u_trk (
      .clk      (clk),
      .rst      (rst),
      .frame_v  (rx_valid[g]),
      .frame_sa (rx_sa[g]),
      .match_sa (match_sa),
      .wr_byte  (store_wr[g]),
      .wr_data  (reg_wdata),
      .last_sa  (last_sa[g]),
      .chg_evt  (chg_evt[g]),
      .mat_evt  (mat_evt[g])
    );
  end

  sam_status_bank #(.NP(NP)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .chg_evt   (chg_evt),
    .mat_evt   (mat_evt),
    .clr_chg   (clr_chg),
    .clr_mat   (clr_mat),
    .en_chg_we (en_chg_we),
    .en_mat_we (en_mat_we),
    .en_chg_d  (en_chg_d),
    .en_mat_d  (en_mat_d),
    .st_chg    (st_chg),
    .st_mat    (st_mat),
    .en_chg    (en_chg),
    .en_mat    (en_mat),
    .irq       (irq)
  );

  sam_reg_if #(.NUM_TP(NUM_TP), .ADDR_W(ADDR_W), .NP(NP), .NB(NB)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .page      (reg_page),
    .addr      (reg_addr),
    .wr        (reg_wr),
    .rd        (reg_rd),
    .wdata     (reg_wdata),
    .st_chg    (st_chg),
    .st_mat    (st_mat),
    .en_chg    (en_chg),
    .en_mat    (en_mat),
    .last_sa   (last_sa),
    .clr_chg   (clr_chg),
    .clr_mat   (clr_mat),
    .en_chg_we (en_chg_we),
    .en_mat_we (en_mat_we),
    .en_chg_d  (en_chg_d),
    .en_mat_d  (en_mat_d),
    .store_wr  (store_wr),
    .match_sa  (match_sa),
    .rdata     (reg_rdata)
  );
endmodule

// File: rtl/sam_monitor_chk.sv
module sam_monitor_chk #(
  parameter int NP     = 9,
  parameter int ADDR_W = 48
) (
  input logic                      clk,
  input logic                      rst,
  input logic [NP-1:0]             rx_valid,
  input logic [NP-1:0][ADDR_W-1:0] rx_sa,
  input logic [NP-1:0][ADDR_W-1:0] last_sa,
  input logic [ADDR_W-1:0]         match_sa,
  input logic [NP-1:0]             st_chg,
  input logic [NP-1:0]             st_mat,
  input logic [NP-1:0]             en_chg,
  input logic [NP-1:0]             en_mat,
  input logic                      irq
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (st_chg == '0 && st_mat == '0 && en_chg == '0 && en_mat == '0 && !irq));

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (st_chg == '0 && st_mat == '0) |-> !irq);

  // R10
  irq_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
    (en_chg == '0 && en_mat == '0) |-> !irq);

  for (genvar i = 0; i < NP; i++) begin : g_chk
    // R3 and R8: a differing address sets the bit even under a read-clear
    sa_change_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[i] && rx_sa[i] != last_sa[i]) |=> st_chg[i]);

    // R3
    store_follow_chk: assert property (@(posedge clk) disable iff (rst)
      rx_valid[i] |=> (last_sa[i] == $past(rx_sa[i])));

    // R5
    match_set_chk: assert property (@(posedge clk) disable iff (rst)
      (rx_valid[i] && rx_sa[i] == match_sa) |=> st_mat[i]);
  end
endmodule

bind sa_port_monitor sam_monitor_chk #(.NP(NUM_TP + 1), .ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .rx_valid (rx_valid),
  .rx_sa    (rx_sa),
  .last_sa  (last_sa),
  .match_sa (match_sa),
  .st_chg   (st_chg),
  .st_mat   (st_mat),
  .en_chg   (en_chg),
  .en_mat   (en_mat),
  .irq      (irq)
);

// File: tb/sim_sa_port_monitor.sv
module sim_sa_port_monitor;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_TP = 8;
  localparam int ADDR_W = 48;
  localparam int NP = NUM_TP + 1;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0] rx_valid = '0;
  logic [NP-1:0][ADDR_W-1:0] rx_sa = '0;
  logic [4:0] reg_page = '0;
  logic [4:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit rd_d = 1'b0;
  exp_t sb_q[$];

  localparam logic [47:0] SA_A = 48'h0011_2233_4455;
  localparam logic [47:0] SA_B = 48'hAABB_CCDD_EEF0;
  localparam logic [47:0] SA_C = 48'h1234_5678_9ABC;
  localparam logic [47:0] SA_D = 48'h0A0B_0C0D_0E0F;

  always #(CLK_PERIOD/2) clk = ~clk;

  sa_port_monitor #(.NUM_TP(NUM_TP), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sa(rx_sa),
    .reg_page(reg_page), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops one expected item per completed read
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (sb_q.size() == 0) begin
        tests++; fails++;
        $display("FAIL scoreboard: got %h expected nothing", reg_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(reg_rdata, e.exp, e.tag);
      end
    end
  end

  task automatic reg_read(input logic [4:0] pg, input logic [4:0] ad,
                          input logic [7:0] exp, input string tag);
    exp_t e;
    @(negedge clk);
    reg_page = pg; reg_addr = ad; reg_rd = 1'b1;
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic reg_write(input logic [4:0] pg, input logic [4:0] ad, input logic [7:0] d);
    @(negedge clk);
    reg_page = pg; reg_addr = ad; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic send(input int port, input logic [47:0] sa);
    @(negedge clk);
    rx_valid[port] = 1'b1; rx_sa[port] = sa;
    @(negedge clk);
    rx_valid[port] = 1'b0;
  endtask

  task automatic write_addr(input logic [4:0] pg, input logic [47:0] sa);
    for (int b = 0; b < 6; b++)
      reg_write(pg, 5'(b), sa[b*8 +: 8]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check({7'b0, irq}, 8'h00, "R1 irq after reset");
    reg_read(5'd1, 5'd6, 8'h00, "R1 status after reset");
    reg_read(5'd2, 5'd6, 8'h00, "R1 enable after reset");

    // R2 first frame, R7 clear on read
    send(3, SA_A);
    reg_read(5'd1, 5'd6, 8'h08, "R2 first frame port3");
    reg_read(5'd1, 5'd6, 8'h00, "R7 cleared by read");
    check({7'b0, irq}, 8'h00, "R10 no irq without enable");

    // R3 same vs different address
    send(3, SA_A);
    reg_read(5'd1, 5'd6, 8'h00, "R3 same address");
    send(3, SA_B);
    reg_read(5'd1, 5'd6, 8'h08, "R3 new address");
    reg_read(5'd19, 5'd0, SA_B[7:0], "R3 store byte0");
    reg_read(5'd19, 5'd5, SA_B[47:40], "R3 store byte5");

    // R4 preload
    write_addr(5'd21, SA_C);
    reg_read(5'd21, 5'd2, SA_C[23:16], "R4 preload readback");
    send(5, SA_C);
    reg_read(5'd1, 5'd6, 8'h00, "R4 preloaded address no change");
    send(5, SA_A);
    reg_read(5'd1, 5'd6, 8'h20, "R4 station change on preloaded port");

    // R5 / R6 match and AUI layout
    write_addr(5'd3, SA_D);
    reg_read(5'd3, 5'd4, SA_D[39:32], "R5 match readback");
    send(2, SA_D);
    reg_read(5'd1, 5'd8, 8'h04, "R5 match port2");
    reg_read(5'd1, 5'd6, 8'h04, "R2 first frame port2");
    send(8, SA_D);
    reg_read(5'd1, 5'd9, 8'h80, "R6 AUI match bit7");
    reg_read(5'd1, 5'd7, 8'h80, "R6 AUI changed bit7");
    reg_read(5'd1, 5'd8, 8'h00, "R7 match cleared");

    // R11 persisting match
    send(2, SA_D);
    reg_read(5'd1, 5'd8, 8'h04, "R11 match set again");
    reg_read(5'd1, 5'd6, 8'h00, "R3 repeated address");

    // R7 writes ignored
    send(0, SA_A);
    reg_write(5'd1, 5'd6, 8'h00);
    reg_read(5'd1, 5'd6, 8'h01, "R7 status write ignored");

    // R9 / R10 enables and irq
    reg_write(5'd2, 5'd6, 8'h02);
    reg_read(5'd2, 5'd6, 8'h02, "R9 enable readback");
    reg_read(5'd2, 5'd6, 8'h02, "R9 read does not clear");
    check({7'b0, irq}, 8'h00, "R10 irq idle");
    send(1, SA_A);
    check({7'b0, irq}, 8'h01, "R10 irq raised");
    reg_write(5'd2, 5'd6, 8'h00);
    check({7'b0, irq}, 8'h00, "R10 irq drop on disable");
    reg_write(5'd2, 5'd6, 8'h02);
    check({7'b0, irq}, 8'h01, "R10 irq back on enable");
    reg_read(5'd1, 5'd6, 8'h02, "R10 status port1");
    check({7'b0, irq}, 8'h00, "R10 irq drop on clear");
    reg_write(5'd2, 5'd9, 8'h80);
    send(8, SA_D);
    check({7'b0, irq}, 8'h01, "R10 AUI match irq");
    reg_read(5'd1, 5'd9, 8'h80, "R10 AUI match status");
    check({7'b0, irq}, 8'h00, "R10 AUI irq cleared");

    // R8 set wins over simultaneous clear
    @(negedge clk);
    rx_valid[6] = 1'b1; rx_sa[6] = SA_A;
    reg_page = 5'd1; reg_addr = 5'd6; reg_rd = 1'b1;
    begin
      exp_t e;
      e.exp = 8'h00; e.tag = "R8 pre-clear value";
      sb_q.push_back(e);
    end
    @(negedge clk);
    rx_valid[6] = 1'b0; reg_rd = 1'b0;
    reg_read(5'd1, 5'd6, 8'h40, "R8 set survives clear");

    // R1 reset mid-run, R2 first frame again
    send(4, SA_A);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check({7'b0, irq}, 8'h00, "R1 irq after second reset");
    reg_read(5'd2, 5'd9, 8'h00, "R1 AUI enable cleared");
    reg_read(5'd1, 5'd6, 8'h00, "R1 status cleared");
    reg_read(5'd3, 5'd0, 8'h00, "R1 match cleared");
    send(3, SA_B);
    reg_read(5'd1, 5'd6, 8'h08, "R2 first frame after reset");

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      tests++; fails++;
      $display("FAIL scoreboard: %0d reads unanswered, expected 0", sb_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule